// File: doc/BRIEF.md
# Serial Flash Status Read Responder

This block is the serial-side front end of a flash device's status logic. It receives an 8-bit instruction, sent most significant bit first, on the serial data input while chip select is low. When the instruction is the status-read opcode, it sends back a status byte on the serial data output. The byte is repeated for as long as chip select stays low, and each copy is rebuilt from the live flag values when its own 8-bit frame starts.

The block also owns the write-enable latch. The enable and disable opcodes set and clear it. Write, program and erase opcodes get through only while the latch is set and the device is idle. When one of them is accepted, the block raises a one-cycle hand-off pulse carrying a command-kind code for the array controller. The latch clears by itself when the busy input falls at the end of that accepted cycle. The busy flag comes from outside, on `busy_in`.

The serial pins use SPI mode 0. Data in is sampled on the rising edge of the serial clock, and data out changes on the falling edge. All three serial inputs are brought into the `clk` domain through a synchronizer chain of parameter depth. The output enable marks when the data pin is driven; when it is low the pin is high impedance.

Top module: `spi_status_responder`

## Requirements
- R1: After reset the output enable is 0, the data output is 0, no command pulse is present, and the write-enable latch is clear, so a status read returns 8'h00.
- R2: The output enable is 0 whenever chip select is high, and throughout the 8 instruction clocks. The data output is 0 whenever the output enable is 0.
- R3: After opcode 8'h05, the status byte is driven starting at the falling serial clock edge that follows the 8th rising edge, most significant bit first. Bits 7..2 are 0, bit 1 is the write-enable latch and bit 0 is the busy flag.
- R4: While chip select stays low, the status byte repeats without limit. Each copy is captured when its own frame starts, so a busy change in the middle of a byte shows up in the next byte.
- R5: A status read is answered while `busy_in` is 1.
- R6: With busy at 0, opcode 8'h06 sets the latch and opcode 8'h04 clears it.
- R7: With busy at 0 and the latch set, opcodes 8'h0A (write), 8'h02 (program) and 8'h D8 (erase) each give exactly one one-cycle `cmd_go` pulse, with `cmd_kind` 0, 1 and 2 respectively. With the latch clear, they give no pulse.
- R8: After an accepted write, program or erase, the falling edge of `busy_in` clears the latch.
- R9: While `busy_in` is 1, every instruction other than status-read is ignored: the latch does not change and no pulse is given.
- R10: Raising chip select aborts a transfer. The output enable returns to 0 within 4 `clk` cycles, and the next transfer starts a fresh instruction count.
- R11: Unknown opcodes, and any bits that follow a non-read opcode, have no effect on the latch, the pulse or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| busy_in | input | 1 | Write/program/erase cycle active |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data pin (0 = high impedance) |
| cmd_go | output | 1 | One-cycle pulse for an accepted write, program or erase |
| cmd_kind | output | 2 | Kind of accepted command: 0 write, 1 program, 2 erase |

## Verification
The latch and the busy flag can only be seen through the status byte. A wrong latch value therefore shows up at bit 1 of the next status frame, which is at most one frame after the instruction that changed it, and also as a missing or extra `cmd_go` pulse on the next gated opcode. A wrong frame counter shows up as the byte shifted or misaligned against the rising edges, or as the output enable going high during the instruction. A bad capture point shows up when a busy change made in the middle of a stream appears in the wrong byte.

// File: rtl/spi_stat_pkg.sv
// Shared constants, opcodes and helpers for the status read responder.
// Assumes MSB-first 8-bit instructions and an 8-bit status frame.
package spi_stat_pkg;

    localparam int OP_BITS   = 8;
    localparam int STAT_BITS = 8;
    localparam int BUSY_POS  = 0;
    localparam int LATCH_POS = 1;

    localparam logic [OP_BITS-1:0] OP_STAT_READ = 8'h05;
    localparam logic [OP_BITS-1:0] OP_LATCH_SET = 8'h06;
    localparam logic [OP_BITS-1:0] OP_LATCH_CLR = 8'h04;
    localparam logic [OP_BITS-1:0] OP_WRITE     = 8'h0A;
    localparam logic [OP_BITS-1:0] OP_PROGRAM   = 8'h02;
    localparam logic [OP_BITS-1:0] OP_ERASE     = 8'hD8;

    typedef enum logic [1:0] {
        KIND_WRITE   = 2'd0,
        KIND_PROGRAM = 2'd1,
        KIND_ERASE   = 2'd2,
        KIND_NONE    = 2'd3
    } cmd_kind_e;

    // Assemble the status frame from the two live flags.
    function automatic logic [STAT_BITS-1:0] make_status(input logic latch, input logic busy);
        logic [STAT_BITS-1:0] s;
        s            = '0;
        s[LATCH_POS] = latch;
        s[BUSY_POS]  = busy;
        return s;
    endfunction

    // Map an opcode to its gated command kind, or KIND_NONE.
    function automatic cmd_kind_e kind_of(input logic [OP_BITS-1:0] op);
        case (op)
            OP_WRITE:   return KIND_WRITE;
            OP_PROGRAM: return KIND_PROGRAM;
            OP_ERASE:   return KIND_ERASE;
            default:    return KIND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
// Brings the three serial inputs into the clk domain through a chain of
// STAGES flops, then flags the rising and falling edges of the serial clock.
// Assumes the serial clock is high and low for at least one clk period each.
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic cs_idle,
    output logic mosi_s,
    output logic sclk_rise,
    output logic sclk_fall
);

    localparam int          LANES = 3;
    localparam logic [2:0]  RST_V = 3'b100;  // {cs_n, sclk, mosi}

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             sclk_d;

    assign raw = {cs_n, sclk, mosi};

    if (STAGES == 1) begin : g_single
        logic [LANES-1:0] stg;
        // One stage: capture the pins directly.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= RST_V;
            else        stg <= raw;
        end
        assign synced = stg;
    end else begin : g_chain
        logic [STAGES-1:0][LANES-1:0] stg;
        // Several stages: shift the pin vector through the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= {STAGES{RST_V}};
            else        stg <= {stg[STAGES-2:0], raw};
        end
        assign synced = stg[STAGES-1];
    end

    // Delayed serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= synced[1];
    end

    assign cs_idle   = synced[2];
    assign mosi_s    = synced[0];
    assign sclk_rise = synced[1] & ~sclk_d;
    assign sclk_fall = ~synced[1] & sclk_d;

endmodule

// File: rtl/spi_opcode_rx.sv
// Shifts in the first OP_BITS of each selected transfer on rising serial
// clock edges and emits the opcode with a one-cycle valid. Later bits of
// the same transfer are ignored. Assumes synchronized inputs.
module spi_opcode_rx
    import spi_stat_pkg::*;
#(
    parameter int W = OP_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_active,
    input  logic         sclk_rise,
    input  logic         mosi,
    output logic         op_valid,
    output logic [W-1:0] op_byte
);

    localparam int CNT_W = $clog2(W);

    typedef enum logic {RX_OPCODE, RX_TAIL} rx_state_e;

    rx_state_e          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [W-1:0]       shreg;

    // Count and shift instruction bits; return to opcode state when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_OPCODE;
            bit_cnt  <= '0;
            shreg    <= '0;
            op_valid <= 1'b0;
            op_byte  <= '0;
        end else begin
            op_valid <= 1'b0;
            if (!cs_active) begin
                state   <= RX_OPCODE;
                bit_cnt <= '0;
            end else if (sclk_rise && state == RX_OPCODE) begin
                shreg   <= {shreg[W-2:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(W - 1)) begin
                    op_byte  <= {shreg[W-2:0], mosi};
                    op_valid <= 1'b1;
                    state    <= RX_TAIL;
                end
            end
        end
    end

endmodule

// File: rtl/spi_latch_gate.sv
// Holds the write-enable latch and gates write, program and erase opcodes
// with it. All non-read opcodes are ignored while busy is high. A cycle
// that was accepted here clears the latch when busy falls.
module spi_latch_gate
    import spi_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [OP_BITS-1:0] op_byte,
    input  logic               busy,
    output logic               latch,
    output logic               cmd_go,
    output logic [1:0]         cmd_kind
);

    cmd_kind_e kind_dec;
    logic      busy_d;
    logic      pending;
    logic      busy_fell;

    assign kind_dec  = kind_of(op_byte);
    assign busy_fell = busy_d & ~busy;

    // Previous busy value, for end-of-cycle detection.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_d <= 1'b0;
        else        busy_d <= busy;
    end

    // Latch update, command gating and end-of-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch    <= 1'b0;
            pending  <= 1'b0;
            cmd_go   <= 1'b0;
            cmd_kind <= KIND_NONE;
        end else begin
            cmd_go <= 1'b0;
            if (pending && busy_fell) begin
                latch   <= 1'b0;
                pending <= 1'b0;
            end
            if (op_valid && !busy) begin
                if (op_byte == OP_LATCH_SET) begin
                    latch <= 1'b1;
                end else if (op_byte == OP_LATCH_CLR) begin
                    latch <= 1'b0;
                end else if (kind_dec != KIND_NONE && latch) begin
                    cmd_go   <= 1'b1;
                    cmd_kind <= kind_dec;
                    pending  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_status_tx.sv
// After a status-read opcode, drives the status frame MSB first on falling
// serial clock edges. It recaptures the flags at the start of every frame
// and releases the pin when deselected.
module spi_status_tx
    import spi_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_active,
    input  logic               sclk_fall,
    input  logic               op_valid,
    input  logic [OP_BITS-1:0] op_byte,
    input  logic               latch,
    input  logic               busy,
    output logic               miso,
    output logic               miso_oe
);

    localparam int LEFT_W = $clog2(STAT_BITS);

    logic                 rd_active;
    logic [STAT_BITS-1:0] sh;
    logic [STAT_BITS-1:0] frame;
    logic [LEFT_W-1:0]    left;

    assign frame = make_status(latch, busy);

    // Frame load, bit shifting and pin release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            sh        <= '0;
            left      <= '0;
            miso      <= 1'b0;
            miso_oe   <= 1'b0;
        end else if (!cs_active) begin
            rd_active <= 1'b0;
            left      <= '0;
            miso      <= 1'b0;
            miso_oe   <= 1'b0;
        end else begin
            if (op_valid && op_byte == OP_STAT_READ)
                rd_active <= 1'b1;
            if (rd_active && sclk_fall) begin
                miso_oe <= 1'b1;
                if (left == '0) begin
                    miso <= frame[STAT_BITS-1];
                    sh   <= {frame[STAT_BITS-2:0], 1'b0};
                    left <= LEFT_W'(STAT_BITS - 1);
                end else begin
                    miso <= sh[STAT_BITS-1];
                    sh   <= {sh[STAT_BITS-2:0], 1'b0};
                    left <= left - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_status_responder.sv
// Top of the status read responder: synchronizer, opcode receiver,
// write-enable gate and status transmitter. The serial clock must stay
// below clk/2 after synchronization.
module spi_status_responder
    import spi_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       busy_in,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    output logic       cmd_go,
    output logic [1:0] cmd_kind
);

    logic               cs_idle;
    logic               cs_active;
    logic               mosi_s;
    logic               sclk_rise;
    logic               sclk_fall;
    logic               op_valid;
    logic [OP_BITS-1:0] op_byte;
    logic               wel;

    assign cs_active = ~cs_idle;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .cs_idle   (cs_idle),
        .mosi_s    (mosi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    spi_opcode_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sclk_rise (sclk_rise),
        .mosi      (mosi_s),
        .op_valid  (op_valid),
        .op_byte   (op_byte)
    );

    spi_latch_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_byte  (op_byte),
        .busy     (busy_in),
        .latch    (wel),
        .cmd_go   (cmd_go),
        .cmd_kind (cmd_kind)
    );

    spi_status_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sclk_fall (sclk_fall),
        .op_valid  (op_valid),
        .op_byte   (op_byte),
        .latch     (wel),
        .busy      (busy_in),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

endmodule

// File: rtl/spi_status_responder_chk.sv
// Assertion checker for the status read responder, bound into the top.
module spi_status_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_idle,
    input logic spi_miso,
    input logic spi_miso_oe,
    input logic busy_in,
    input logic cmd_go,
    input logic wel
);

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !spi_miso_oe);

    // R2
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);

    // R7
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);

    // R7
    go_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> $past(wel));

    // R9
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> !$past(busy_in));

    // R9
    latch_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy_in));

endmodule

bind spi_status_responder spi_status_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_idle     (cs_idle),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .busy_in     (busy_in),
    .cmd_go      (cmd_go),
    .wel         (wel)
);

// File: tb/spi_status_responder_bench.sv
module spi_status_responder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       busy_in = 1'b0;
    logic       spi_miso;
    logic       spi_miso_oe;
    logic       cmd_go;
    logic [1:0] cmd_kind;

    int         checks = 0;
    int         errors = 0;
    int         go_cnt = 0;
    logic [1:0] go_kind = 2'd3;
    logic [7:0] exp_q[$];
    logic       cur_is_read = 1'b0;
    string      cur_tag = "R3";

    logic       m_wel = 1'b0;
    logic       m_pending = 1'b0;
    int         m_go = 0;
    logic [1:0] m_kind = 2'd3;

    always #2.5 clk = ~clk;

    spi_status_responder u_spi_status_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .busy_in     (busy_in),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .cmd_go      (cmd_go),
        .cmd_kind    (cmd_kind)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    // Command pulse monitor.
    always @(negedge clk) begin
        if (cmd_go) begin
            go_cnt++;
            go_kind = cmd_kind;
        end
    end

    // Scoreboard monitor: checks the pin release during the instruction and
    // compares each received status byte against the queue.
    initial begin
        int         rise_idx = 0;
        int         nbits = 0;
        logic [7:0] acc = '0;
        forever begin
            @(posedge spi_sclk or posedge spi_cs_n);
            if (spi_cs_n) begin
                rise_idx = 0;
                nbits    = 0;
            end else begin
                check(spi_miso_oe == (cur_is_read && rise_idx >= 8), "R2 oe",
                      spi_miso_oe, (cur_is_read && rise_idx >= 8));
                rise_idx++;
                if (spi_miso_oe) begin
                    acc = {acc[6:0], spi_miso};
                    nbits++;
                    if (nbits == 8) begin
                        nbits = 0;
                        if (exp_q.size() == 0) begin
                            check(1'b0, {cur_tag, " extra byte"}, acc, 0);
                        end else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            check(acc == e, {cur_tag, " status byte"}, acc, e);
                        end
                    end
                end
            end
        end
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_busy(input logic v);
        if (m_pending && busy_in && !v) begin
            m_wel     = 1'b0;
            m_pending = 1'b0;
        end
        busy_in = v;
    endtask

    task automatic apply_op(input logic [7:0] op);
        if (busy_in) return;
        case (op)
            8'h06: m_wel = 1'b1;
            8'h04: m_wel = 1'b0;
            8'h0A, 8'h02, 8'hD8: if (m_wel) begin
                m_go++;
                m_kind    = (op == 8'h0A) ? 2'd0 : (op == 8'h02) ? 2'd1 : 2'd2;
                m_pending = 1'b1;
            end
            default: ;
        endcase
    endtask

    // Driver: one transfer; pushes the expected frame at each frame start.
    task automatic xfer(input logic [7:0] op, input int nbytes, input int flip_byte,
                        input logic flip_val, input int abort_bit);
        logic rd;
        rd = (op == 8'h05);
        cur_is_read = rd;
        @(negedge clk);
        spi_cs_n = 1'b0;
        half();
        for (int i = 0; i < 8; i++) begin
            spi_mosi = op[7-i];
            half();
            spi_sclk = 1'b1;
            half();
            if (i == 7 && rd) exp_q.push_back({6'b0, m_wel, busy_in});
            spi_sclk = 1'b0;
        end
        apply_op(op);
        for (int b = 0; b < nbytes; b++) begin
            for (int j = 0; j < 8; j++) begin
                spi_mosi = ~spi_mosi;
                half();
                if (abort_bit == b * 8 + j) begin
                    spi_cs_n = 1'b1;
                    if (rd && exp_q.size() > 0) void'(exp_q.pop_back());
                    repeat (4) @(negedge clk);
                    check(!spi_miso_oe, "R10 abort release", spi_miso_oe, 0);
                    cur_is_read = 1'b0;
                    half();
                    return;
                end
                spi_sclk = 1'b1;
                half();
                if (b == flip_byte && j == 3) set_busy(flip_val);
                if (j == 7 && rd && b < nbytes - 1) exp_q.push_back({6'b0, m_wel, busy_in});
                spi_sclk = 1'b0;
            end
        end
        half();
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        half();
        cur_is_read = 1'b0;
        half();
    endtask

    task automatic rd_status(input int nbytes, input string tag);
        cur_tag = tag;
        xfer(8'h05, nbytes, -1, 1'b0, -1);
        check(exp_q.size() == 0, {tag, " frames done"}, exp_q.size(), 0);
    endtask

    task automatic check_go(input string tag);
        check(go_cnt == m_go, {tag, " pulse count"}, go_cnt, m_go);
        if (m_go > 0) check(go_kind == m_kind, {tag, " kind"}, go_kind, m_kind);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!spi_miso_oe, "R1 oe", spi_miso_oe, 0);
        check(!spi_miso, "R1 miso", spi_miso, 0);
        check(!cmd_go, "R1 go", cmd_go, 0);
        rd_status(1, "R1");

        // R6 set latch, R4 repeat frames, R3 layout
        xfer(8'h06, 0, -1, 1'b0, -1);
        rd_status(3, "R4");

        // R5 read while busy; R9 clear ignored while busy
        set_busy(1'b1);
        rd_status(1, "R5");
        xfer(8'h04, 0, -1, 1'b0, -1);
        rd_status(1, "R9");
        set_busy(1'b0);

        // R6 clear latch
        xfer(8'h04, 0, -1, 1'b0, -1);
        rd_status(1, "R6");

        // R7 program blocked with latch clear
        xfer(8'h02, 1, -1, 1'b0, -1);
        check_go("R7 blocked");

        // R7 program accepted, R11 trailing bits, R8 clear at cycle end
        xfer(8'h06, 0, -1, 1'b0, -1);
        xfer(8'h02, 2, -1, 1'b0, -1);
        check_go("R7 program");
        rd_status(1, "R8 before");
        set_busy(1'b1);
        rd_status(1, "R8 busy");
        set_busy(1'b0);
        repeat (2) @(negedge clk);
        rd_status(1, "R8 after");

        // R9 erase ignored while busy; then erase and write accepted
        xfer(8'h06, 0, -1, 1'b0, -1);
        set_busy(1'b1);
        xfer(8'hD8, 0, -1, 1'b0, -1);
        check_go("R9 erase busy");
        set_busy(1'b0);
        xfer(8'hD8, 0, -1, 1'b0, -1);
        check_go("R7 erase");
        xfer(8'h0A, 1, -1, 1'b0, -1);
        check_go("R7 write");
        set_busy(1'b1);
        repeat (3) @(negedge clk);
        set_busy(1'b0);
        repeat (2) @(negedge clk);
        rd_status(1, "R8 write end");

        // R11 unknown opcode with latch set
        xfer(8'h06, 0, -1, 1'b0, -1);
        cur_tag = "R11";
        xfer(8'h9F, 2, -1, 1'b0, -1);
        check_go("R11 unknown");
        rd_status(1, "R11");

        // R4 busy clears mid-stream: next frame shows it
        set_busy(1'b1);
        cur_tag = "R4 midstream";
        xfer(8'h05, 3, 0, 1'b0, -1);
        check(exp_q.size() == 0, "R4 midstream done", exp_q.size(), 0);

        // R10 abort during a frame, then a fresh transfer
        cur_tag = "R10";
        xfer(8'h05, 2, -1, 1'b0, 3);
        xfer(8'h04, 0, -1, 1'b0, -1);
        rd_status(2, "R10 fresh");

        check(exp_q.size() == 0, "R4 queue empty", exp_q.size(), 0);
        finish_run();
    end

endmodule